// File: doc/BRIEF.md
# Firmware Hub Nibble-Serial Read Initiator

This block is the host end of a four-bit serial read transaction to a firmware memory. A local client offers one read request: a 4-bit device select and a 28-bit byte address. The block sends these one nibble per clock, marked by a one-clock active-low frame strobe. It then gives up the shared data lines over two turnaround clocks. After that it watches the target's sync nibbles until the target reports ready, and rebuilds the byte from the two nibbles that follow.

The tri-state data bus is shown as three signals: a driven nibble, an output enable, and a sampled input nibble. These connect to a pad outside the block. The wait limit is a parameter. A target that stalls beyond the limit, or sends a sync code the block does not know, ends the transaction with an error response. The response is a single-clock pulse that carries the byte and an error flag.

Top module: `fwh_read_init`

## Requirements
- R1: `req_ready` is high only while the block is idle, and a request is accepted on a clock edge where `req_valid` and `req_ready` are both high. In the first clock after acceptance, `frame_n` is low for exactly that one clock, with `bus_oe` high and `bus_out` = 4'b1101.
- R2: The clocks after the start nibble drive these fields, in order and with `bus_oe` high:
  - clock 2: the select nibble.
  - clocks 3 to 9: the seven address nibbles, most significant first (bits 27:24 down to bits 3:0).
  - clock 10: the size nibble 4'b0000.
- R3: Clock 11 drives 4'b1111 with `bus_oe` high. From clock 12 until the response clock, `bus_oe` stays low.
- R4: From clock 13 on, one input nibble is sampled per clock. The value 4'b0101 is a wait and sampling continues. The value 4'b0000 is ready, and a read that ends this way responds with `rsp_err` = 0.
- R5: In the two clocks after the ready nibble, the first nibble sampled becomes `rsp_data[3:0]` and the second becomes `rsp_data[7:4]`.
- R6: The block waits two target turnaround clocks after the data and then pulses `rsp_valid` high for exactly one clock. With n waits, the pulse comes in clock 18+n: with three sync clocks, the transaction fills clocks 1 to 19 and the response appears in clock 20.
- R7: MAX_WAIT consecutive waits are accepted. Sampling wait number MAX_WAIT+1 ends the transaction in the next clock with `rsp_valid` = 1, `rsp_err` = 1 and `rsp_data` = 0.
- R8: A sync nibble other than 4'b0101 or 4'b0000 ends the transaction in the next clock with `rsp_valid` = 1, `rsp_err` = 1 and `rsp_data` = 0.
- R9: While a transaction is in progress, `req_ready` stays low. Changes on `req_valid`, `req_sel` and `req_addr` have no effect on the nibbles driven or on the response.
- R10: After reset, `frame_n` = 1, `bus_oe` = 0, `rsp_valid` = 0 and `req_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request offered |
| req_ready | output | 1 | Block idle, request will be taken |
| req_sel | input | 4 | Device select nibble |
| req_addr | input | 28 | Byte address |
| rsp_valid | output | 1 | One-clock response pulse |
| rsp_data | output | 8 | Byte read (0 on error) |
| rsp_err | output | 1 | Transaction ended on timeout or bad sync |
| frame_n | output | 1 | Active-low frame strobe |
| bus_out | output | 4 | Nibble driven onto the bus |
| bus_oe | output | 1 | Output enable for bus_out |
| bus_in | input | 4 | Nibble sampled from the bus |

## Verification
The bench drives the read with no waits, with exactly MAX_WAIT waits and with one wait more than that. These catch an off-by-one in the wait limit: such a design either times out a legal read or hangs one read longer than allowed. An unknown sync code checks that the block does not treat any nonzero nibble as a wait. Distinct high and low data nibbles expose a swapped byte assembly. Address and select inputs that change during the transaction expose a design that re-samples the request port instead of holding its own copy. A clock-by-clock check of the output enable catches a host that drives during either turnaround.

// File: rtl/fwh_pkg.sv
package fwh_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_SEL, ST_ADDR, ST_SIZE, ST_HTAR0, ST_HTAR1,
    ST_SYNC, ST_DLO, ST_DHI, ST_TTAR0, ST_TTAR1
  } fwh_state_e;

  localparam logic [3:0] NIB_START  = 4'b1101;
  localparam logic [3:0] NIB_SIZE1  = 4'b0000;
  localparam logic [3:0] NIB_TAR    = 4'b1111;
  localparam logic [3:0] SYNC_WAIT  = 4'b0101;
  localparam logic [3:0] SYNC_READY = 4'b0000;
endpackage

// File: rtl/fwh_wait_ctr.sv
module fwh_wait_ctr #(
  parameter int MAX_WAIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic over
);
  localparam int CW = $clog2(MAX_WAIT + 1);
  logic [CW-1:0] cnt;

  // over: the next wait sampled would be one beyond the limit
  assign over = (cnt == CW'(MAX_WAIT));

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc && !over) cnt <= cnt + 1'b1;
  end

  assert_wait_bound_R7: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(MAX_WAIT));
endmodule

// File: rtl/fwh_byte_asm.sv
module fwh_byte_asm #(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_lo,
  input  logic             cap_hi,
  input  logic [NIB_W-1:0] nib,
  output logic [2*NIB_W-1:0] data
);
  logic [NIB_W-1:0] lo_q, hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (cap_lo) lo_q <= nib;
      if (cap_hi) hi_q <= nib;
    end
  end

  assign data = {hi_q, lo_q};

  // the high nibble always directly follows the low nibble
  assert_lo_first_R5: assert property (@(posedge clk) disable iff (rst)
    cap_hi |-> $past(cap_lo));
endmodule

// File: rtl/fwh_read_init.sv
module fwh_read_init
  import fwh_pkg::*;
#(
  parameter int ADDR_W   = 28,
  parameter int MAX_WAIT = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [3:0]        req_sel,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [7:0]        rsp_data,
  output logic              rsp_err,
  output logic              frame_n,
  output logic [3:0]        bus_out,
  output logic              bus_oe,
  input  logic [3:0]        bus_in
);
  localparam int ADDR_NIBS = ADDR_W / 4;
  localparam int NC_W      = (ADDR_NIBS > 1) ? $clog2(ADDR_NIBS) : 1;

  fwh_state_e        state, nxt;
  logic [NC_W-1:0]   nib_cnt;
  logic [3:0]        sel_q;
  logic [ADDR_W-1:0] addr_sr;
  logic              finish_ok, finish_err;
  logic              wait_over;
  logic [7:0]        byte_val;

  assign req_ready = (state == ST_IDLE);

  fwh_wait_ctr #(.MAX_WAIT(MAX_WAIT)) u_wait (
    .clk (clk),
    .rst (rst),
    .clr (state != ST_SYNC),
    .inc (state == ST_SYNC && bus_in == SYNC_WAIT),
    .over(wait_over)
  );

  fwh_byte_asm #(.NIB_W(4)) u_asm (
    .clk   (clk),
    .rst   (rst),
    .cap_lo(state == ST_DLO),
    .cap_hi(state == ST_DHI),
    .nib   (bus_in),
    .data  (byte_val)
  );

  always_comb begin
    nxt        = state;
    finish_ok  = 1'b0;
    finish_err = 1'b0;
    case (state)
      ST_IDLE:  if (req_valid) nxt = ST_START;
      ST_START: nxt = ST_SEL;
      ST_SEL:   nxt = ST_ADDR;
      ST_ADDR:  if (nib_cnt == NC_W'(ADDR_NIBS - 1)) nxt = ST_SIZE;
      ST_SIZE:  nxt = ST_HTAR0;
      ST_HTAR0: nxt = ST_HTAR1;
      ST_HTAR1: nxt = ST_SYNC;
      ST_SYNC: begin
        if (bus_in == SYNC_READY) nxt = ST_DLO;
        else if (bus_in == SYNC_WAIT) begin
          if (wait_over) begin
            nxt        = ST_IDLE;
            finish_err = 1'b1;
          end
        end else begin
          nxt        = ST_IDLE;
          finish_err = 1'b1;
        end
      end
      ST_DLO:   nxt = ST_DHI;
      ST_DHI:   nxt = ST_TTAR0;
      ST_TTAR0: nxt = ST_TTAR1;
      ST_TTAR1: begin
        nxt       = ST_IDLE;
        finish_ok = 1'b1;
      end
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || state != ST_ADDR) nib_cnt <= '0;
    else nib_cnt <= nib_cnt + 1'b1;
  end

  // bus outputs are registered from the next state
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      frame_n   <= 1'b1;
      bus_out   <= NIB_TAR;
      bus_oe    <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_data  <= '0;
      sel_q     <= '0;
      addr_sr   <= '0;
    end else begin
      state     <= nxt;
      rsp_valid <= finish_ok | finish_err;
      rsp_err   <= finish_err;
      if (finish_ok)       rsp_data <= byte_val;
      else if (finish_err) rsp_data <= '0;
      if (state == ST_IDLE && req_valid) begin
        sel_q   <= req_sel;
        addr_sr <= req_addr;
      end
      frame_n <= (nxt != ST_START);
      case (nxt)
        ST_START: begin bus_out <= NIB_START; bus_oe <= 1'b1; end
        ST_SEL:   begin bus_out <= sel_q;     bus_oe <= 1'b1; end
        ST_ADDR: begin
          bus_out <= addr_sr[ADDR_W-1 -: 4];
          bus_oe  <= 1'b1;
          addr_sr <= {addr_sr[ADDR_W-5:0], 4'h0};
        end
        ST_SIZE:  begin bus_out <= NIB_SIZE1; bus_oe <= 1'b1; end
        ST_HTAR0: begin bus_out <= NIB_TAR;   bus_oe <= 1'b1; end
        default:  begin bus_out <= NIB_TAR;   bus_oe <= 1'b0; end
      endcase
    end
  end

  assert_one_clk_frame_R1: assert property (@(posedge clk) disable iff (rst)
    !frame_n |=> frame_n);
  assert_accept_start_R1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (!frame_n && bus_oe && bus_out == NIB_START));
  assert_target_owns_bus_R3: assert property (@(posedge clk) disable iff (rst)
    (state inside {ST_SYNC, ST_DLO, ST_DHI, ST_TTAR0, ST_TTAR1}) |-> !bus_oe);
  assert_rsp_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  assert_ok_after_tar_R6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_err) |-> $past(state) == ST_TTAR1);
  assert_bad_sync_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SYNC && bus_in != SYNC_WAIT && bus_in != SYNC_READY)
      |=> (rsp_valid && rsp_err));
endmodule

// File: tb/fwh_read_init_bench.sv
module fwh_read_init_bench;
  localparam int MW = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_sel = '0;
  logic [27:0] req_addr = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic        rsp_err;
  logic        frame_n;
  logic [3:0]  bus_out;
  logic        bus_oe;
  logic [3:0]  bus_in = 4'hF;

  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  fwh_read_init #(.ADDR_W(28), .MAX_WAIT(MW)) u_fwh_read_init (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_sel(req_sel), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_err(rsp_err), .frame_n(frame_n),
    .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one read; term = sync nibble after the waits; scramble pokes the request port while busy
  task automatic do_read(input logic [3:0] sel, input logic [27:0] addr,
                         input int nwait, input logic [3:0] term,
                         input logic [7:0] data, input bit scramble);
    int  rclk;
    bit  exp_err;
    logic [3:0] exp_out;
    string tag;
    if (nwait > MW) begin rclk = 14 + MW; exp_err = 1'b1; end
    else if (term == 4'h0) begin rclk = 18 + nwait; exp_err = 1'b0; end
    else begin rclk = 14 + nwait; exp_err = 1'b1; end
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready before request", 32'(req_ready), 1);
    req_valid = 1'b1; req_sel = sel; req_addr = addr;
    @(posedge clk);
    for (int k = 1; k <= rclk; k++) begin
      @(negedge clk);
      if (scramble && k < rclk) begin
        req_valid = 1'b1; req_sel = ~sel; req_addr = ~addr;
      end else req_valid = 1'b0;
      if (k >= 13 && k < 13 + nwait && k <= 13 + MW) bus_in = 4'h5;
      else if (k == 13 + nwait) bus_in = term;
      else if (!exp_err && k == 14 + nwait) bus_in = data[3:0];
      else if (!exp_err && k == 15 + nwait) bus_in = data[7:4];
      else bus_in = 4'hF;
      chk(frame_n == (k != 1), "R1", $sformatf("frame_n clk %0d", k), 32'(frame_n), 32'(k != 1));
      chk(bus_oe == (k <= 11), "R3", $sformatf("bus_oe clk %0d", k), 32'(bus_oe), 32'(k <= 11));
      if (k <= 11) begin
        if (k == 1) begin exp_out = 4'hD; tag = "R1"; end
        else if (k == 2) begin exp_out = sel; tag = "R2"; end
        else if (k <= 9) begin exp_out = addr[27 - 4*(k-3) -: 4]; tag = "R2"; end
        else if (k == 10) begin exp_out = 4'h0; tag = "R2"; end
        else begin exp_out = 4'hF; tag = "R3"; end
        chk(bus_out == exp_out, tag, $sformatf("bus_out clk %0d", k), 32'(bus_out), 32'(exp_out));
      end
      if (k < rclk) begin
        chk(rsp_valid == 1'b0, "R6", $sformatf("early rsp clk %0d", k), 32'(rsp_valid), 0);
        chk(req_ready == 1'b0, "R9", $sformatf("ready busy clk %0d", k), 32'(req_ready), 0);
      end else begin
        tag = (nwait > MW) ? "R7" : (exp_err ? "R8" : "R4");
        chk(rsp_valid == 1'b1, "R6", "rsp_valid", 32'(rsp_valid), 1);
        chk(rsp_err == exp_err, tag, "rsp_err", 32'(rsp_err), 32'(exp_err));
        chk(rsp_data == (exp_err ? 8'h00 : data), exp_err ? tag : "R5", "rsp_data",
            32'(rsp_data), 32'(exp_err ? 8'h00 : data));
        chk(req_ready == 1'b1, "R9", "ready after rsp", 32'(req_ready), 1);
      end
    end
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R6", "rsp pulse width", 32'(rsp_valid), 0);
    chk(frame_n == 1'b1, "R9", "no extra start", 32'(frame_n), 1);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(frame_n == 1'b1, "R10", "frame_n", 32'(frame_n), 1);
    chk(bus_oe == 1'b0, "R10", "bus_oe", 32'(bus_oe), 0);
    chk(rsp_valid == 1'b0, "R10", "rsp_valid", 32'(rsp_valid), 0);
    chk(req_ready == 1'b1, "R10", "req_ready", 32'(req_ready), 1);
  endtask

  task automatic t_three_sync;   do_read(4'h3, 28'h1234567, 2, 4'h0, 8'hA5, 1'b0); endtask
  task automatic t_no_wait;      do_read(4'hC, 28'hFEDCBA9, 0, 4'h0, 8'h3C, 1'b0); endtask
  task automatic t_wait_limit;   do_read(4'h0, 28'h0F0F0F0, MW, 4'h0, 8'h96, 1'b0); endtask
  task automatic t_timeout;      do_read(4'h5, 28'h8000001, MW + 1, 4'h0, 8'h11, 1'b0); endtask
  task automatic t_bad_sync;     do_read(4'h9, 28'h0000000, 1, 4'hA, 8'h77, 1'b0); endtask
  task automatic t_busy_ignore;  do_read(4'h6, 28'h5A5A5A5, 3, 4'h0, 8'hE1, 1'b1); endtask

  initial begin
    t_reset();
    t_three_sync();
    t_no_wait();
    t_wait_limit();
    t_timeout();
    t_bad_sync();
    t_busy_ignore();
    t_three_sync();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule